// File: doc/BRIEF.md
# Ethernet Receive Packet Ring

This block holds received Ethernet frames until a host collects them. Frames arrive as a byte stream marked with first-byte and last-byte flags. Each accepted frame goes into the next free slot of a fixed ring of packet slots. There it becomes a record: a two-byte length field, then the frame bytes, then four trailing bytes whose contents are unspecified. The value in the length field is the frame size plus 6. The host reads one 32-bit word per DATA read. Each word is assembled little-endian from the oldest record. When the last word of a record has been read, that slot is released.

Reception is gated by an enable input. A frame that arrives while the enable is low, or while every slot is occupied, is discarded with no error. A frame too large for a slot is discarded and reported through a one-cycle overrun pulse. A FIFO-reset input empties the ring. The host can also read the number of stored packets through a second register. The defaults are 31 slots of 128 bytes. The slot size is a parameter and can be set to 2048 where storage allows.

Top module: `rxr_ring`

## Requirements
- R1: After reset the packet count is 0, `rx_avail` is low and `rx_overrun` is low.
- R2: A frame is admitted when its first byte arrives while the enable is high and the count is below SLOTS. The count rises by one in the cycle that takes its last byte. A count read (`rd_sel`=1) returns the count in bits 7:0 and zero above.
- R3: Each record reads out as bytes in order, four per DATA read (`rd_sel`=0). Byte k of the record sits in bits 8k+7:8k. Record bytes 0 and 1 hold size+6, least significant byte first. Bytes 2 to size+1 hold the frame bytes in arrival order.
- R4: A record takes exactly ceil((size+6)/4) DATA reads. The last of them frees the slot, decrements the count and moves the read point to the next record.
- R5: A frame whose first byte arrives while `rx_enable` is low is not stored.
- R6: A frame that starts while the count equals SLOTS is dropped. The count is unchanged and `rx_overrun` stays low.
- R7: A frame of size SLOT_BYTES-6 or more is not stored. `rx_overrun` pulses high for one cycle in the cycle after its last byte. A frame one byte shorter is stored normally.
- R8: A DATA read while the count is 0 returns 0 and leaves the ring unchanged.
- R9: A `fifo_reset` pulse sets the count to 0 and the read offset to 0. It also abandons any frame in progress. The next stored frame reads out from its first word.
- R10: Slots are used in ring order modulo SLOTS. Frames read out in arrival order across the wrap point, including the case of a full ring.
- R11: `rx_avail` is high exactly when the count is nonzero.
- R12: A count read changes neither the count nor the read position within a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable, sampled at a frame's first byte |
| fifo_reset | input | 1 | Empties the ring and abandons a frame in progress |
| in_valid | input | 1 | Byte strobe of the incoming frame stream |
| in_data | input | 8 | Incoming frame byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| rd_en | input | 1 | Host register read strobe |
| rd_sel | input | 1 | 0 selects DATA, 1 selects the packet count |
| rd_data | output | 32 | Value of the latest read, valid from the cycle after `rd_en` |
| rx_avail | output | 1 | At least one packet is stored |
| rx_overrun | output | 1 | One-cycle pulse for an oversized frame |

## Verification
The bench fills the ring to exactly SLOTS entries and offers one more frame. A design that compared against the wrong bound would overwrite the oldest record or raise a false overrun. It sends frames of 1 to 5 bytes, so the final word is partly padding and some records end mid-word. An off-by-one in the release test would then eat a word of the next record or stall on a finished one. The frames at sizes SLOT_BYTES-6 and SLOT_BYTES-7 sit exactly on the overrun limit. The bench also resets the FIFO both partway through a record and partway through an incoming frame. A design that kept a stale offset or finished the abandoned frame would hand back misaligned or phantom data.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int REC_EXTRA = 6;
  localparam int HDR_BYTES = 2;

  typedef enum logic {
    SEL_DATA  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  // Sum of two ring indices, wrapped to the ring size.
  function automatic int ring_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // Record length stored in front of a frame of the given size.
  function automatic int rec_len(input int sz);
    return sz + REC_EXTRA;
  endfunction

  // True when reading word index w finishes a record of length len.
  function automatic logic last_word(input int w, input int len);
    return ((w + 1) * 4 >= len);
  endfunction

endpackage

// File: rtl/rxr_intake.sv
module rxr_intake #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int IW    = $clog2(SLOTS),
  localparam int BW    = $clog2(SLOT_BYTES),
  localparam int LW    = BW + 1,
  localparam int LIMIT = SLOT_BYTES - rxr_pkg::REC_EXTRA,
  localparam int CNTW  = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          rx_enable,
  input  logic          flush,
  input  logic          ring_full,
  input  logic [IW-1:0] tail_slot,
  output logic          wr_en,
  output logic [IW-1:0] wr_slot,
  output logic [BW-1:0] wr_off,
  output logic [7:0]    wr_byte,
  output logic          admit,
  output logic          commit,
  output logic [IW-1:0] commit_slot,
  output logic [LW-1:0] commit_len,
  output logic          overrun
);

  logic            active_q;
  logic [IW-1:0]   slot_q;
  logic [CNTW-1:0] cnt_q;
  logic            start, live, in_room, size_ok, end_frame;
  logic [CNTW-1:0] idx, idx_inc;

  assign start   = in_valid && in_first;
  assign admit   = start && rx_enable && !ring_full && !flush;
  assign live    = in_valid && !flush && (admit || (active_q && !in_first));
  assign idx     = start ? '0 : cnt_q;
  assign idx_inc = (idx == CNTW'(LIMIT)) ? idx : idx + 1'b1;
  assign in_room = idx < CNTW'(LIMIT);
  assign size_ok = idx < CNTW'(LIMIT - 1);
  assign end_frame = live && in_last;

  assign wr_slot = admit ? tail_slot : slot_q;
  assign wr_en   = live && in_room;
  assign wr_off  = BW'(idx) + BW'(rxr_pkg::HDR_BYTES);
  assign wr_byte = in_data;

  assign commit      = end_frame && size_ok;
  assign commit_slot = wr_slot;
  assign commit_len  = LW'(rxr_pkg::rec_len(int'(idx) + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      cnt_q    <= '0;
      overrun  <= 1'b0;
    end else begin
      overrun <= end_frame && !size_ok;
      if (flush) begin
        active_q <= 1'b0;
      end else if (admit) begin
        active_q <= !in_last;
        slot_q   <= tail_slot;
        cnt_q    <= idx_inc;
      end else if (start) begin
        active_q <= 1'b0;
      end else if (live) begin
        cnt_q <= idx_inc;
        if (in_last) active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxr_store.sv
module rxr_store #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int IW    = $clog2(SLOTS),
  localparam int BW    = $clog2(SLOT_BYTES),
  localparam int LW    = BW + 1,
  localparam int WPS   = SLOT_BYTES / 4,
  localparam int WAW   = $clog2(WPS),
  localparam int DEPTH = SLOTS * WPS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_slot,
  input  logic [BW-1:0]  wr_off,
  input  logic [7:0]     wr_byte,
  input  logic           len_we,
  input  logic [IW-1:0]  len_slot,
  input  logic [LW-1:0]  len_val,
  input  logic [IW-1:0]  rd_slot,
  input  logic [WAW-1:0] rd_word,
  output logic [31:0]    rd_bytes,
  output logic [LW-1:0]  rd_len
);

  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] len_mem [SLOTS];

  assign wr_addr = AW'(wr_slot) * AW'(WPS) + AW'(wr_off >> 2);
  assign rd_addr = AW'(rd_slot) * AW'(WPS) + AW'(rd_word);

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_off[1:0] == 2'(ln))) lane_mem[wr_addr] <= wr_byte;
    end
    assign rd_bytes[8*ln +: 8] = lane_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (len_we) len_mem[len_slot] <= len_val;
  end

  assign rd_len = len_mem[rd_slot];

endmodule

// File: rtl/rxr_drain.sv
module rxr_drain #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int CW  = $clog2(SLOTS + 1),
  localparam int BW  = $clog2(SLOT_BYTES),
  localparam int LW  = BW + 1,
  localparam int WAW = $clog2(SLOT_BYTES / 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic           rd_sel,
  input  logic           flush,
  input  logic [CW-1:0]  count,
  input  logic [31:0]    word_in,
  input  logic [LW-1:0]  rec_len,
  output logic [WAW-1:0] word_idx,
  output logic           pop,
  output logic [31:0]    rd_data
);

  logic [WAW-1:0] woff_q;
  logic           has_pkt, data_rd, take;
  logic [15:0]    len16;
  logic [31:0]    word_out;

  assign has_pkt  = count != '0;
  assign data_rd  = rd_en && (rd_sel == rxr_pkg::SEL_DATA);
  assign take     = data_rd && has_pkt && !flush;
  assign pop      = take && rxr_pkg::last_word(int'(woff_q), int'(rec_len));
  assign word_idx = woff_q;
  assign len16    = 16'(rec_len);
  assign word_out = (woff_q == '0) ? {word_in[31:16], len16} : word_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      woff_q  <= '0;
      rd_data <= '0;
    end else begin
      if (flush)     woff_q <= '0;
      else if (pop)  woff_q <= '0;
      else if (take) woff_q <= woff_q + 1'b1;
      if (rd_en) begin
        if (rd_sel == rxr_pkg::SEL_COUNT) rd_data <= 32'(count);
        else if (has_pkt)                 rd_data <= word_out;
        else                              rd_data <= '0;
      end
    end
  end

endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_enable,
  input  logic        fifo_reset,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_first,
  input  logic        in_last,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        rx_avail,
  output logic        rx_overrun
);

  localparam int IW  = $clog2(SLOTS);
  localparam int CW  = $clog2(SLOTS + 1);
  localparam int BW  = $clog2(SLOT_BYTES);
  localparam int LW  = BW + 1;
  localparam int WAW = $clog2(SLOT_BYTES / 4);

  logic [IW-1:0]  head_q, tail_slot, wr_slot, commit_slot;
  logic [CW-1:0]  count_q;
  logic           ring_full, wr_en, admit, commit, pop;
  logic [BW-1:0]  wr_off;
  logic [7:0]     wr_byte;
  logic [LW-1:0]  commit_len, head_len;
  logic [WAW-1:0] word_idx;
  logic [31:0]    head_word;

  assign tail_slot = IW'(rxr_pkg::ring_add(int'(head_q), int'(count_q), SLOTS));
  assign ring_full = count_q == CW'(SLOTS);
  assign rx_avail  = count_q != '0;

  rxr_intake #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_intake (
    .clk, .rst_n, .in_valid, .in_data, .in_first, .in_last, .rx_enable,
    .flush(fifo_reset), .ring_full, .tail_slot,
    .wr_en, .wr_slot, .wr_off, .wr_byte, .admit, .commit,
    .commit_slot, .commit_len, .overrun(rx_overrun)
  );

  rxr_store #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_store (
    .clk, .wr_en, .wr_slot, .wr_off, .wr_byte,
    .len_we(commit), .len_slot(commit_slot), .len_val(commit_len),
    .rd_slot(head_q), .rd_word(word_idx), .rd_bytes(head_word), .rd_len(head_len)
  );

  rxr_drain #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk, .rst_n, .rd_en, .rd_sel, .flush(fifo_reset), .count(count_q),
    .word_in(head_word), .rec_len(head_len), .word_idx, .pop, .rd_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (fifo_reset) count_q <= '0;
      else            count_q <= count_q + CW'(commit) - CW'(pop);
      if (pop) head_q <= IW'(rxr_pkg::ring_add(int'(head_q), 1, SLOTS));
    end
  end

endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
  parameter int SLOTS = 31,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_reset,
  input logic          in_valid,
  input logic          in_first,
  input logic          rx_enable,
  input logic          rd_en,
  input logic          rd_sel,
  input logic [31:0]   rd_data,
  input logic          rx_avail,
  input logic          rx_overrun,
  input logic [CW-1:0] count_q,
  input logic          admit,
  input logic          commit,
  input logic          pop
);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(SLOTS));

  assert_no_commit_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(SLOTS)) |-> !commit);

  assert_disabled_no_admit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && !rx_enable) |-> !admit);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> !rx_avail);

  assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !rx_avail && !fifo_reset && !commit)
      |=> (rd_data == 32'd0) && $stable(count_q));

  assert_pop_needs_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> rx_avail);

  assert_ovr_not_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !rx_overrun);

  assert_avail_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> $past(commit));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pop && !fifo_reset) |=> (count_q == $past(count_q) + 1'b1));

endmodule

bind rxr_ring rxr_ring_chk #(.SLOTS(SLOTS)) u_chk (
  .clk, .rst_n, .fifo_reset, .in_valid, .in_first, .rx_enable,
  .rd_en, .rd_sel, .rd_data, .rx_avail, .rx_overrun,
  .count_q, .admit, .commit, .pop
);

// File: tb/tb_rxr_ring.sv
module tb_rxr_ring;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 31;
  localparam int SLOT_BYTES = 128;
  localparam int LIMIT      = SLOT_BYTES - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0, fifo_reset = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rx_avail, rx_overrun;

  int checks = 0, fails = 0;
  int q_id[$], q_sz[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_ring #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) dut (
    .clk, .rst_n, .rx_enable, .fifo_reset, .in_valid, .in_data, .in_first,
    .in_last, .rd_en, .rd_sel, .rd_data, .rx_avail, .rx_overrun
  );

  function automatic logic [7:0] fbyte(int id, int i);
    return 8'(id * 37 + i * 11 + 5);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] val);
    @(negedge clk); rd_en = 1'b1; rd_sel = sel;
    @(negedge clk); rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic check_count(int exp, string req);
    logic [31:0] v;
    read_reg(1'b1, v);
    check(v == 32'(exp), req, v, exp);
    check(rx_avail == (exp != 0), "R11", rx_avail, exp != 0);
  endtask

  task automatic send_frame(int id, int sz, bit stored, output bit ovr);
    for (int i = 0; i < sz; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fbyte(id, i);
      in_first = (i == 0); in_last = (i == sz - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    ovr = rx_overrun;
    if (stored) begin q_id.push_back(id); q_sz.push_back(sz); end
  endtask

  task automatic drain_one(string req);
    int id, sz, len, nw;
    logic [31:0] v, ex, mk;
    id = q_id.pop_front(); sz = q_sz.pop_front();
    len = sz + 6; nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      read_reg(1'b0, v);
      ex = '0; mk = '0;
      for (int b = 0; b < 4; b++) begin
        int k;
        k = w * 4 + b;
        if (k == 0)          begin ex[8*b +: 8] = 8'(len);      mk[8*b +: 8] = 8'hff; end
        else if (k == 1)     begin ex[8*b +: 8] = 8'(len >> 8); mk[8*b +: 8] = 8'hff; end
        else if (k < sz + 2) begin ex[8*b +: 8] = fbyte(id, k - 2); mk[8*b +: 8] = 8'hff; end
      end
      check((v & mk) == ex, req, v & mk, ex);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(rx_avail == 1'b0, "R1", rx_avail, 0);
    check(rx_overrun == 1'b0, "R1", rx_overrun, 0);
    check_count(0, "R1");
    read_reg(1'b0, v);
    check(v == 0, "R8", v, 0);
    check_count(0, "R8");
  endtask

  task automatic t_single;
    bit o;
    send_frame(1, 10, 1, o);
    check(o == 0, "R2", o, 0);
    check_count(1, "R2");
    drain_one("R3");
    check_count(0, "R4");
  endtask

  task automatic t_sizes;
    bit o;
    int sizes[6] = '{1, 2, 3, 4, 5, 60};
    foreach (sizes[i]) send_frame(10 + i, sizes[i], 1, o);
    check_count(6, "R2");
    for (int i = 0; i < 6; i++) drain_one("R4");
    check_count(0, "R4");
  endtask

  task automatic t_disabled;
    bit o;
    rx_enable = 1'b0;
    send_frame(20, 8, 0, o);
    check_count(0, "R5");
    rx_enable = 1'b1;
  endtask

  task automatic t_full;
    bit o;
    for (int i = 0; i < SLOTS; i++) send_frame(100 + i, 3 + (i % 5), 1, o);
    check_count(SLOTS, "R6");
    send_frame(200, 5, 0, o);
    check(o == 0, "R6", o, 0);
    check_count(SLOTS, "R6");
    for (int i = 0; i < SLOTS; i++) drain_one("R10");
    check_count(0, "R10");
  endtask

  task automatic t_oversize;
    bit o;
    send_frame(30, LIMIT, 0, o);
    check(o == 1, "R7", o, 1);
    @(negedge clk);
    check(rx_overrun == 0, "R7", rx_overrun, 0);
    check_count(0, "R7");
    send_frame(31, LIMIT - 1, 1, o);
    check(o == 0, "R7", o, 0);
    check_count(1, "R7");
    drain_one("R7");
  endtask

  task automatic t_flush;
    bit o;
    logic [31:0] v;
    send_frame(40, 12, 1, o);
    send_frame(41, 9, 1, o);
    read_reg(1'b0, v);
    @(negedge clk); fifo_reset = 1'b1;
    @(negedge clk); fifo_reset = 1'b0;
    q_id.delete(); q_sz.delete();
    check_count(0, "R9");
    send_frame(42, 7, 1, o);
    check_count(1, "R9");
    drain_one("R9");
    // abandon a frame in the middle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = fbyte(43, i);
      in_first = (i == 0); in_last = 1'b0;
    end
    @(negedge clk); in_valid = 1'b0; in_first = 1'b0; fifo_reset = 1'b1;
    @(negedge clk); fifo_reset = 1'b0;
    for (int i = 4; i < 8; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = fbyte(43, i);
      in_last = (i == 7);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    check_count(0, "R9");
  endtask

  task automatic t_empty_then_np;
    bit o;
    logic [31:0] v;
    read_reg(1'b0, v);
    check(v == 0, "R8", v, 0);
    send_frame(50, 11, 1, o);
    read_reg(1'b1, v);
    read_reg(1'b1, v);
    check(v == 1, "R12", v, 1);
    drain_one("R12");
    check_count(0, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_enable = 1'b1;
    t_single();
    t_sizes();
    t_disabled();
    t_full();
    t_oversize();
    t_flush();
    t_empty_then_np();
    t_full();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule